// File: doc/BRIEF.md
# Filtered Prefetch Issue Queue

This block holds the prefetch operations of one thread and sends them to the data cache. Each entry carries a prefetch address, an operation id and an operand tag. An entry can take part in selection only after its operands are ready. Operands are either ready when the entry is written or become ready later, when a wakeup broadcasts the entry's tag.

A small table remembers the cache blocks that were prefetched most recently. When a ready entry targets a block that is still in this table, the entry is retired on the completion port and no memory request is made. Any other ready entry goes to the cache when the cache says it can accept a request. Its block address then goes into the table, and the request carries the cycle number at which it was issued.

Selection is oldest-first. In one cycle the block can retire at most one redundant entry and issue at most one request. The two are counted separately, so a retirement never uses up the issue slot.

Top module: `pfq_filter`

## Requirements
- R1: After reset the queue is empty (`full_o`, `req_vld_o` and `done_vld_o` low) and the history is empty, so the first prefetch to any block is issued.
- R2: An entry whose operands are not ready is neither issued nor retired. Younger ready entries behind it are still served.
- R3: A wakeup with a given tag makes waiting entries that carry that tag eligible from the next cycle on. A wakeup in the same cycle as an enqueue also applies to the entry being written.
- R4: When `acc_i` is high, the oldest ready entry whose block is not in the history is presented on `req_vld_o`/`req_addr_o`/`req_id_o` in the cycle after it is enqueued, and is removed at the clock edge. No more than one request is issued per cycle, and `req_vld_o` is never high while `acc_i` is low.
- R5: While `acc_i` is low, a ready non-redundant entry stays queued and is issued once `acc_i` rises.
- R6: The block of every issued request is recorded in the history. A later ready entry for the same block is retired through `done_vld_o`/`done_id_o` and produces no request.
- R7: Retiring a redundant entry does not use the issue slot. A retirement and an issue can happen in the same cycle, and a retirement also takes place while `acc_i` is low.
- R8: Redundancy is judged on the block address, which is the address bits from `BLK_OFF` (default 6, 64-byte blocks) upward. Addresses that differ only below bit 6 are redundant. A difference at bit 6 or above is not.
- R9: The history holds `HIST_N` (default 8) blocks and replaces them first-in first-out. The most recent block is still filtered, and a block followed by 8 newer issues no longer is.
- R10: `full_o` is high when `DEPTH` (default 4) entries are held. An enqueue while full is ignored. Entries leave in age order.
- R11: `req_cyc_o` equals the number of clock edges since reset was released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_vld_i | input | 1 | Write a new prefetch entry |
| enq_addr_i | input | 32 | Prefetch byte address |
| enq_id_i | input | 6 | Operation id |
| enq_tag_i | input | 4 | Operand tag to wait on |
| enq_rdy_i | input | 1 | Operands already ready on entry |
| full_o | output | 1 | Queue holds DEPTH entries |
| wk_vld_i | input | 1 | Operand wakeup broadcast |
| wk_tag_i | input | 4 | Tag being woken |
| acc_i | input | 1 | Data cache can accept a prefetch |
| req_vld_o | output | 1 | Prefetch request issued this cycle |
| req_addr_o | output | 32 | Request address |
| req_id_o | output | 6 | Request operation id |
| req_cyc_o | output | 32 | Issue cycle stamp |
| done_vld_o | output | 1 | Redundant entry retired this cycle |
| done_id_o | output | 6 | Id of the retired entry |

## Verification
The assertions are checked on every cycle. They cover the following: a request is never made without cache acceptance, the history never records a block it already holds, the entry count stays within bounds, an enqueue while full never adds an entry, and issue stamps advance by one across back-to-back issues. Other behaviours depend on particular input sequences, and only the directed scenarios show them. These are the bypass of a waiting entry, the wakeup timing, a retirement and an issue in the same cycle, the offset-versus-block address comparison, first-in first-out eviction from the history, and the age order in which a full queue drains.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  parameter int unsigned PF_ADDR_W = 32;
  parameter int unsigned PF_ID_W   = 6;
  parameter int unsigned PF_TAG_W  = 4;

  typedef struct packed {
    logic                 vld;
    logic                 rdy;
    logic [PF_TAG_W-1:0]  tag;
    logic [PF_ADDR_W-1:0] addr;
    logic [PF_ID_W-1:0]   id;
  } pf_entry_t;
endpackage

// File: rtl/pfq_ffs.sv
module pfq_ffs #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins (oldest entry)
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pfq_hist.sv
module pfq_hist #(
  parameter int unsigned N      = 8,
  parameter int unsigned PROBES = 4,
  parameter int unsigned BLK_W  = 26,
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  probe_i [PROBES],
  output logic [PROBES-1:0] hit_o,
  input  logic              wr_i,
  input  logic [BLK_W-1:0]  wr_blk_i
);
  logic [BLK_W-1:0] blk_q [N];
  logic [N-1:0]     vld_q;
  logic [PW-1:0]    wp_q;

  for (genvar p = 0; p < PROBES; p++) begin : g_probe
    logic [N-1:0] match;
    for (genvar h = 0; h < N; h++) begin : g_cmp
      assign match[h] = vld_q[h] && (blk_q[h] == probe_i[p]);
    end
    assign hit_o[p] = |match;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      wp_q  <= '0;
      for (int h = 0; h < N; h++) blk_q[h] <= '0;
    end else if (wr_i) begin
      blk_q[wp_q] <= wr_blk_i;
      vld_q[wp_q] <= 1'b1;
      wp_q        <= (wp_q == PW'(N - 1)) ? '0 : wp_q + 1'b1;
    end
  end

  logic wr_dup;
  always_comb begin
    wr_dup = 1'b0;
    for (int h = 0; h < N; h++)
      if (vld_q[h] && blk_q[h] == wr_blk_i) wr_dup = 1'b1;
  end

  // R6
  hist_no_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !wr_dup);
endmodule

// File: rtl/pfq_filter.sv
module pfq_filter
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned HIST_N  = 8,
  parameter int unsigned BLK_OFF = 6,
  parameter int unsigned CYC_W   = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enq_vld_i,
  input  logic [PF_ADDR_W-1:0] enq_addr_i,
  input  logic [PF_ID_W-1:0]   enq_id_i,
  input  logic [PF_TAG_W-1:0]  enq_tag_i,
  input  logic                 enq_rdy_i,
  output logic                 full_o,
  input  logic                 wk_vld_i,
  input  logic [PF_TAG_W-1:0]  wk_tag_i,
  input  logic                 acc_i,
  output logic                 req_vld_o,
  output logic [PF_ADDR_W-1:0] req_addr_o,
  output logic [PF_ID_W-1:0]   req_id_o,
  output logic [CYC_W-1:0]     req_cyc_o,
  output logic                 done_vld_o,
  output logic [PF_ID_W-1:0]   done_id_o
);
  localparam int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam int unsigned BLK_W = PF_ADDR_W - BLK_OFF;

  pf_entry_t        q_q [DEPTH];
  pf_entry_t        q_d [DEPTH];
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CYC_W-1:0] cyc_q;

  logic [BLK_W-1:0] probe [DEPTH];
  logic [DEPTH-1:0] hit, iss_req, drp_req;
  logic             iss_found, drp_found;
  logic [IW-1:0]    iss_idx, drp_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign probe[i]   = q_q[i].addr[PF_ADDR_W-1:BLK_OFF];
    assign iss_req[i] = q_q[i].vld && q_q[i].rdy && !hit[i];
    assign drp_req[i] = q_q[i].vld && q_q[i].rdy &&  hit[i];
  end

  pfq_hist #(.N(HIST_N), .PROBES(DEPTH), .BLK_W(BLK_W)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .probe_i  (probe),
    .hit_o    (hit),
    .wr_i     (req_vld_o),
    .wr_blk_i (req_addr_o[PF_ADDR_W-1:BLK_OFF])
  );

  pfq_ffs #(.N(DEPTH)) u_iss_pick (.req_i(iss_req), .found_o(iss_found), .idx_o(iss_idx));
  pfq_ffs #(.N(DEPTH)) u_drp_pick (.req_i(drp_req), .found_o(drp_found), .idx_o(drp_idx));

  assign full_o     = (cnt_q == CW'(DEPTH));
  assign req_vld_o  = iss_found && acc_i;
  assign req_addr_o = q_q[iss_idx].addr;
  assign req_id_o   = q_q[iss_idx].id;
  assign req_cyc_o  = cyc_q;
  assign done_vld_o = drp_found;
  assign done_id_o  = q_q[drp_idx].id;

  // compact survivors toward slot 0, then append the new entry
  always_comb begin
    logic [CW-1:0] n;
    logic          keep;
    n = '0;
    for (int i = 0; i < DEPTH; i++) q_d[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      keep = q_q[i].vld
          && !(req_vld_o  && iss_idx == IW'(i))
          && !(done_vld_o && drp_idx == IW'(i));
      if (keep) begin
        q_d[IW'(n)] = q_q[i];
        if (wk_vld_i && q_q[i].tag == wk_tag_i) q_d[IW'(n)].rdy = 1'b1;
        n = n + 1'b1;
      end
    end
    if (enq_vld_i && !full_o) begin
      q_d[IW'(n)].vld  = 1'b1;
      q_d[IW'(n)].rdy  = enq_rdy_i || (wk_vld_i && enq_tag_i == wk_tag_i);
      q_d[IW'(n)].tag  = enq_tag_i;
      q_d[IW'(n)].addr = enq_addr_i;
      q_d[IW'(n)].id   = enq_id_i;
      n = n + 1'b1;
    end
    cnt_d = n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cyc_q <= '0;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      cyc_q <= cyc_q + 1'b1;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= q_d[i];
    end
  end

  // R4
  req_needs_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_o |-> acc_i);

  // R10
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R10
  full_no_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && enq_vld_i) |=> cnt_q <= $past(cnt_q));

  // R11
  stamp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_o && $past(req_vld_o)) |-> req_cyc_o == $past(req_cyc_o) + 1'b1);
endmodule

// File: tb/pfq_filter_tb.sv
`timescale 1ns/1ps
module pfq_filter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enq_vld_i = 1'b0;
  logic [31:0] enq_addr_i = '0;
  logic [5:0]  enq_id_i = '0;
  logic [3:0]  enq_tag_i = '0;
  logic        enq_rdy_i = 1'b0;
  logic        full_o;
  logic        wk_vld_i = 1'b0;
  logic [3:0]  wk_tag_i = '0;
  logic        acc_i = 1'b0;
  logic        req_vld_o;
  logic [31:0] req_addr_o;
  logic [5:0]  req_id_o;
  logic [31:0] req_cyc_o;
  logic        done_vld_o;
  logic [5:0]  done_id_o;

  int checks = 0;
  int errors = 0;
  int bcyc   = 0;
  bit fin    = 1'b0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) if (rst_ni) bcyc <= bcyc + 1;

  pfq_filter u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic enq(input logic [31:0] a, input logic [5:0] id, input logic [3:0] tg, input logic r);
    enq_vld_i = 1'b1; enq_addr_i = a; enq_id_i = id; enq_tag_i = tg; enq_rdy_i = r;
  endtask

  task automatic clr();
    enq_vld_i = 1'b0; wk_vld_i = 1'b0;
  endtask

  task automatic exp_req(input string req, input logic [5:0] id);
    #1;
    chk(req_vld_o === 1'b1, req, req_vld_o, 1);
    chk(req_id_o === id, req, req_id_o, id);
  endtask

  task automatic exp_none(input string req);
    #1;
    chk(req_vld_o === 1'b0, req, req_vld_o, 0);
    chk(done_vld_o === 1'b0, req, done_vld_o, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(full_o === 1'b0, "R1", full_o, 0);
    chk(req_vld_o === 1'b0, "R1", req_vld_o, 0);
    chk(done_vld_o === 1'b0, "R1", done_vld_o, 0);
  endtask

  task automatic t_basic();
    acc_i = 1'b1;
    enq(32'h1000, 6'd1, 4'd0, 1'b1);
    exp_none("R4");
    tick(); clr();
    exp_req("R1 R4", 6'd1);
    chk(req_addr_o === 32'h1000, "R4", req_addr_o, 32'h1000);
    chk(req_cyc_o === 32'(bcyc), "R11", req_cyc_o, bcyc);
    tick();
    exp_none("R4");
  endtask

  task automatic t_wait();
    enq(32'h3000, 6'd3, 4'd3, 1'b0);
    tick();
    enq(32'h2000, 6'd2, 4'd0, 1'b1);
    exp_none("R2");
    tick(); clr();
    exp_req("R2", 6'd2);
    tick();
    exp_none("R2");
    wk_vld_i = 1'b1; wk_tag_i = 4'd3;
    exp_none("R3");
    tick(); clr();
    exp_req("R3", 6'd3);
    chk(req_cyc_o === 32'(bcyc), "R11", req_cyc_o, bcyc);
    tick();
  endtask

  task automatic t_stall();
    acc_i = 1'b0;
    enq(32'h4000, 6'd4, 4'd0, 1'b1);
    tick(); clr();
    for (int k = 0; k < 3; k++) begin
      exp_none("R5");
      tick();
    end
    acc_i = 1'b1;
    exp_req("R5", 6'd4);
    tick();
    exp_none("R5");
  endtask

  task automatic t_redundant();
    enq(32'h1010, 6'd5, 4'd0, 1'b1);
    tick(); clr();
    #1;
    chk(done_vld_o === 1'b1, "R6 R8", done_vld_o, 1);
    chk(done_id_o === 6'd5, "R6", done_id_o, 5);
    chk(req_vld_o === 1'b0, "R6", req_vld_o, 0);
    tick();
    exp_none("R6");
    enq(32'h1040, 6'd6, 4'd0, 1'b1);
    tick(); clr();
    exp_req("R8", 6'd6);
    chk(done_vld_o === 1'b0, "R8", done_vld_o, 0);
    tick();
  endtask

  task automatic t_same_cycle();
    enq(32'h2008, 6'd7, 4'd5, 1'b0);
    tick();
    enq(32'h5000, 6'd8, 4'd5, 1'b0);
    tick(); clr();
    exp_none("R7");
    wk_vld_i = 1'b1; wk_tag_i = 4'd5;
    tick(); clr();
    exp_req("R7", 6'd8);
    chk(done_vld_o === 1'b1, "R7", done_vld_o, 1);
    chk(done_id_o === 6'd7, "R7", done_id_o, 7);
    tick();
    exp_none("R7");
    acc_i = 1'b0;
    enq(32'h2030, 6'd9, 4'd0, 1'b1);
    tick(); clr();
    #1;
    chk(done_vld_o === 1'b1 && done_id_o === 6'd9, "R7", done_id_o, 9);
    tick();
    acc_i = 1'b1;
  endtask

  task automatic t_fifo();
    for (int k = 0; k < 8; k++) begin
      enq(32'h8000 + 32'(k) * 32'h100, 6'(10 + k), 4'd0, 1'b1);
      tick(); clr();
      exp_req("R9", 6'(10 + k));
      tick();
    end
    enq(32'h8704, 6'd20, 4'd0, 1'b1);
    tick(); clr();
    #1;
    chk(done_vld_o === 1'b1 && done_id_o === 6'd20, "R9", done_id_o, 20);
    tick();
    enq(32'h1000, 6'd21, 4'd0, 1'b1);
    tick(); clr();
    exp_req("R9", 6'd21);
    chk(done_vld_o === 1'b0, "R9", done_vld_o, 0);
    tick();
  endtask

  task automatic t_full();
    acc_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      enq(32'h9000 + 32'(k) * 32'h100, 6'(30 + k), 4'd7, 1'b0);
      tick();
    end
    clr();
    #1;
    chk(full_o === 1'b1, "R10", full_o, 1);
    enq(32'h9400, 6'd34, 4'd0, 1'b1);
    tick(); clr();
    #1;
    chk(full_o === 1'b1, "R10", full_o, 1);
    wk_vld_i = 1'b1; wk_tag_i = 4'd7; acc_i = 1'b1;
    tick(); clr();
    for (int k = 0; k < 4; k++) begin
      exp_req("R10", 6'(30 + k));
      tick();
    end
    exp_none("R10");
    chk(full_o === 1'b0, "R10", full_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    @(negedge clk_i);
    t_basic();
    t_wait();
    t_stall();
    t_redundant();
    t_same_cycle();
    t_fifo();
    t_full();
    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule